// File: doc/BRIEF.md
# Multi-Socket Latch Capture Sequencer

This block runs the acquisition sweep of a test fixture that reads raw bit streams out of latch-cell test chips. It waits for a start byte from a serial receiver. It then drives a socket select toward an external chip multiplexer and a cell select toward the multiplexer inside the chip. For every cell it records a fixed number of streams of fixed length. The cells are swept first and the sockets second. Every sampled bit passes through an input flip-flop, is packed into words and is written to a block RAM at a linearly rising address.

The block also generates the slow clock that drives the chips, by dividing its own reference clock. Each captured bit is taken a fixed number of reference cycles after a rising edge of that slow clock, so the latch has settled before it is read. While the sweep runs, a busy flag is high and further start bytes have no effect. When the last word of the last stream of the last cell on the last socket has been written, a done flag comes up.

With the defaults, the block covers six sockets and 256 cells per socket. Each cell gives 21 streams of 1,024 bits, in 32-bit words. The chip clock is the reference divided by 20.

Top module: `lcs_capture_seq`

## Requirements
- R1: A sweep starts only on a cycle where `rx_valid` is high and `rx_byte` equals `START_CODE` (default 8'hA5) while the block is not busy; `busy` is high from the next cycle. Any other byte leaves the block idle, with no RAM write.
- R2: While `busy` is high, start bytes are ignored. The running sweep is not restarted, and its address sequence continues unbroken.
- R3: `chip_clk` runs from reset with a period of `CLK_DIV` reference cycles. It is high for `CLK_DIV/2` of them and low for the rest.
- R4: During a sweep, exactly one bit of `cell_bit` is captured per `chip_clk` period. It is taken on the reference edge that falls `SETTLE_CYC` cycles after the cycle in which `chip_clk` went high. The sweep holds `NUM_SOCKETS*NUM_CELLS*NUM_STREAMS*STREAM_BITS` bits in total.
- R5: The bit order is bits within a stream, then streams, then cells, then sockets. Bit k is taken with `socket_sel` = 1 + k / (NUM_CELLS*NUM_STREAMS*STREAM_BITS) and `cell_sel` = (k / (NUM_STREAMS*STREAM_BITS)) mod NUM_CELLS. Both selects stay in range at all times: 1 to NUM_SOCKETS, and below NUM_CELLS.
- R6: Bits are packed first-captured into bit 0 of `ram_wdata`. A word is written with a one-cycle `ram_we` pulse two reference cycles after the capture edge of its last bit.
- R7: The word address is 0 for the first word of each sweep and rises by one for each word. A sweep writes exactly (total bits)/`WORD_W` words, and only while `busy` is high.
- R8: In the cycle after the final word is written, `busy` falls and `done` rises. `done` then holds until a new start is accepted, and `busy` and `done` are never high together.
- R9: After a sweep, `socket_sel` is back at 1 and `cell_sel` at 0.
- R10: In reset, `busy`, `done` and `ram_we` are low, `socket_sel` is 1, `cell_sel` is 0 and `chip_clk` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A byte is present on rx_byte this cycle |
| rx_byte | input | 8 | Byte from the serial receiver |
| chip_clk | output | 1 | Divided clock that drives the latch chips |
| cell_bit | input | 1 | Output of the selected latch cell |
| socket_sel | output | $clog2(NUM_SOCKETS+1) | Selected socket, counting from 1 |
| cell_sel | output | $clog2(NUM_CELLS) | Selected cell, counting from 0 |
| ram_we | output | 1 | One-cycle write strobe for the capture RAM |
| ram_addr | output | $clog2(total words) | Word address of the write |
| ram_wdata | output | WORD_W | Packed word, first bit in bit 0 |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | Last sweep has finished |

## Verification
The bench shrinks the sweep to two sockets, three cells, two streams of eight bits and four-bit words, so every carry between levels is crossed several times. A wrong carry would show up as a select that disagrees with the bit index at capture time, and an early or late capture point would shift the recorded bits against the packed words. A start byte sent mid-sweep targets a design that restarts: it would drop the address back to zero and fail the address check. The bench also sends a wrong byte while idle, which a loose start decode would accept. Finally, it runs a second sweep after the first to catch a done flag that does not clear, or an address counter that is not rewound.

// File: rtl/lcs_pkg.sv
package lcs_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RUN   = 2'd1,
      ST_DRAIN = 2'd2,
      ST_FIN   = 2'd3
   } lcs_state_e;
endpackage

// File: rtl/lcs_clkgen.sv
// Divides the reference clock into the chip clock and marks the settle point.
module lcs_clkgen #(
   parameter int unsigned CLK_DIV    = 20,
   parameter int unsigned SETTLE_CYC = 3
) (
   input  logic clk,
   input  logic rst_n,
   output logic chip_clk,
   output logic smp_stb
);
   localparam int unsigned CW   = $clog2(CLK_DIV);
   localparam int unsigned HALF = CLK_DIV / 2;

   logic [CW-1:0] cnt;
   logic [CW-1:0] cnt_nxt;

   always_comb begin
      if (cnt == CW'(CLK_DIV - 1)) cnt_nxt = '0;
      else                         cnt_nxt = cnt + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt      <= '0;
         chip_clk <= 1'b1;
      end else begin
         cnt      <= cnt_nxt;
         chip_clk <= (cnt_nxt < CW'(HALF));
      end
   end

   // cnt == 0 is the first cycle of the high phase
   assign smp_stb = (cnt == CW'(SETTLE_CYC));
endmodule

// File: rtl/lcs_sweep.sv
// Four nested wrap counters: bit, stream, cell, socket (innermost first).
module lcs_sweep #(
   parameter int unsigned BITS    = 1024,
   parameter int unsigned STREAMS = 21,
   parameter int unsigned CELLS   = 256,
   parameter int unsigned SOCKETS = 6,
   parameter int unsigned IW      = 11
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic                adv,
   output logic [3:0][IW-1:0]  idx,
   output logic                wrap_all
);
   localparam int unsigned LIM [4] = '{BITS, STREAMS, CELLS, SOCKETS};

   logic [4:0] carry;
   assign carry[0] = adv;

   for (genvar g = 0; g < 4; g++) begin : g_lvl
      logic at_max;
      assign at_max     = (idx[g] == IW'(LIM[g] - 1));
      assign carry[g+1] = carry[g] & at_max;

      always_ff @(posedge clk) begin
         if (!rst_n || clr)   idx[g] <= '0;
         else if (carry[g])   idx[g] <= at_max ? '0 : idx[g] + 1'b1;
      end
   end

   assign wrap_all = carry[4];
endmodule

// File: rtl/lcs_packer.sv
// Input register, word assembly (first bit in bit 0) and linear RAM addressing.
module lcs_packer #(
   parameter int unsigned WORD_W = 32,
   parameter int unsigned ADDR_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              smp,
   input  logic              din,
   output logic              ram_we,
   output logic [ADDR_W-1:0] ram_addr,
   output logic [WORD_W-1:0] ram_wdata
);
   localparam int unsigned FW = $clog2(WORD_W);

   logic              bit_q;
   logic              bit_v;
   logic [FW-1:0]     fill;
   logic [WORD_W-1:0] shreg;
   logic [ADDR_W-1:0] acnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bit_q     <= 1'b0;
         bit_v     <= 1'b0;
         fill      <= '0;
         shreg     <= '0;
         acnt      <= '0;
         ram_we    <= 1'b0;
         ram_addr  <= '0;
         ram_wdata <= '0;
      end else begin
         ram_we <= 1'b0;
         bit_v  <= smp;
         if (smp) bit_q <= din;
         if (clr) begin
            fill <= '0;
            acnt <= '0;
         end else if (bit_v) begin
            if (fill == FW'(WORD_W - 1)) begin
               ram_we    <= 1'b1;
               ram_wdata <= {bit_q, shreg[WORD_W-2:0]};
               ram_addr  <= acnt;
               acnt      <= acnt + 1'b1;
               fill      <= '0;
            end else begin
               shreg[fill] <= bit_q;
               fill        <= fill + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/lcs_capture_seq.sv
module lcs_capture_seq #(
   parameter int unsigned NUM_SOCKETS = 6,
   parameter int unsigned NUM_CELLS   = 256,
   parameter int unsigned NUM_STREAMS = 21,
   parameter int unsigned STREAM_BITS = 1024,
   parameter int unsigned WORD_W      = 32,
   parameter int unsigned CLK_DIV     = 20,
   parameter int unsigned SETTLE_CYC  = 3,
   parameter logic [7:0]  START_CODE  = 8'hA5,
   localparam int unsigned SOCK_W     = $clog2(NUM_SOCKETS + 1),
   localparam int unsigned CELL_W     = (NUM_CELLS > 1) ? $clog2(NUM_CELLS) : 1,
   localparam int unsigned TOT_WORDS  = NUM_SOCKETS * NUM_CELLS * NUM_STREAMS * STREAM_BITS / WORD_W,
   localparam int unsigned ADDR_W     = (TOT_WORDS > 1) ? $clog2(TOT_WORDS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [7:0]        rx_byte,
   output logic              chip_clk,
   input  logic              cell_bit,
   output logic [SOCK_W-1:0] socket_sel,
   output logic [CELL_W-1:0] cell_sel,
   output logic              ram_we,
   output logic [ADDR_W-1:0] ram_addr,
   output logic [WORD_W-1:0] ram_wdata,
   output logic              busy,
   output logic              done
);
   import lcs_pkg::*;

   localparam int unsigned M01  = (STREAM_BITS > NUM_STREAMS) ? STREAM_BITS : NUM_STREAMS;
   localparam int unsigned M23  = (NUM_CELLS > NUM_SOCKETS) ? NUM_CELLS : NUM_SOCKETS;
   localparam int unsigned MAXL = (M01 > M23) ? M01 : M23;
   localparam int unsigned IW   = $clog2(MAXL + 1);

   // elaboration-time parameter checks
   if (WORD_W < 2) begin : g_bad_word
      $error("WORD_W must be at least 2");
   end
   if (STREAM_BITS % WORD_W != 0) begin : g_bad_pack
      $error("STREAM_BITS must be a multiple of WORD_W");
   end
   if (CLK_DIV < 2) begin : g_bad_div
      $error("CLK_DIV must be at least 2");
   end
   if (SETTLE_CYC >= CLK_DIV / 2) begin : g_bad_settle
      $error("SETTLE_CYC must fall inside the high phase");
   end
   if (NUM_SOCKETS < 1 || NUM_CELLS < 1 || NUM_STREAMS < 1) begin : g_bad_cnt
      $error("sweep counts must be non-zero");
   end

   lcs_state_e        state;
   logic              smp_stb;
   logic              run_stb;
   logic              start_ok;
   logic              wrap_all;
   logic [3:0][IW-1:0] idx;

   assign start_ok = rx_valid && (rx_byte == START_CODE) &&
                     (state == ST_IDLE || state == ST_FIN);
   assign run_stb  = smp_stb && (state == ST_RUN);

   lcs_clkgen #(.CLK_DIV(CLK_DIV), .SETTLE_CYC(SETTLE_CYC)) u_clk (
      .clk      (clk),
      .rst_n    (rst_n),
      .chip_clk (chip_clk),
      .smp_stb  (smp_stb)
   );

   lcs_sweep #(
      .BITS(STREAM_BITS), .STREAMS(NUM_STREAMS), .CELLS(NUM_CELLS),
      .SOCKETS(NUM_SOCKETS), .IW(IW)
   ) u_sweep (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (start_ok),
      .adv      (run_stb),
      .idx      (idx),
      .wrap_all (wrap_all)
   );

   lcs_packer #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_pack (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (start_ok),
      .smp       (run_stb),
      .din       (cell_bit),
      .ram_we    (ram_we),
      .ram_addr  (ram_addr),
      .ram_wdata (ram_wdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
      end else begin
         unique case (state)
            ST_IDLE, ST_FIN: if (start_ok) state <= ST_RUN;
            ST_RUN:          if (run_stb && wrap_all) state <= ST_DRAIN;
            ST_DRAIN:        if (ram_we) state <= ST_FIN;
            default:         state <= ST_IDLE;
         endcase
      end
   end

   assign busy       = (state == ST_RUN) || (state == ST_DRAIN);
   assign done       = (state == ST_FIN);
   assign socket_sel = SOCK_W'(idx[3]) + SOCK_W'(1);
   assign cell_sel   = CELL_W'(idx[2]);
endmodule

// File: rtl/lcs_capture_seq_chk.sv
module lcs_capture_seq_chk #(
   parameter int unsigned NUM_SOCKETS = 6,
   parameter int unsigned NUM_CELLS   = 256,
   parameter int unsigned SOCK_W      = 3,
   parameter int unsigned CELL_W      = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic              ram_we,
   input logic [SOCK_W-1:0] socket_sel,
   input logic [CELL_W-1:0] cell_sel
);
   a_r8_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));
   a_r7_write_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> busy);
   a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |=> !ram_we);
   a_r5_socket_range: assert property (@(posedge clk) disable iff (!rst_n)
      (socket_sel >= SOCK_W'(1)) && (socket_sel <= SOCK_W'(NUM_SOCKETS)));
   a_r5_cell_range: assert property (@(posedge clk) disable iff (!rst_n)
      cell_sel <= CELL_W'(NUM_CELLS - 1));
   a_r5_cell_moves_busy: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cell_sel) |-> $past(busy));
   a_r8_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(ram_we));
endmodule

bind lcs_capture_seq lcs_capture_seq_chk #(
   .NUM_SOCKETS(NUM_SOCKETS), .NUM_CELLS(NUM_CELLS),
   .SOCK_W(SOCK_W), .CELL_W(CELL_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .busy       (busy),
   .done       (done),
   .ram_we     (ram_we),
   .socket_sel (socket_sel),
   .cell_sel   (cell_sel)
);

// File: tb/sim_lcs_capture_seq.sv
`timescale 1ns/1ps
module sim_lcs_capture_seq;
   localparam int NS = 2, NC = 3, NSTR = 2, NB = 8, W = 4, DIV = 4, SETTLE = 1;
   localparam logic [7:0] CODE = 8'hA5;
   localparam int TOT_BITS  = NS * NC * NSTR * NB;
   localparam int TOT_WORDS = TOT_BITS / W;
   localparam int SOCK_W = $clog2(NS + 1);
   localparam int CELL_W = $clog2(NC);
   localparam int ADDR_W = $clog2(TOT_WORDS);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_valid = 1'b0;
   logic [7:0] rx_byte = 8'h00;
   logic cell_bit = 1'b0;
   logic chip_clk;
   logic [SOCK_W-1:0] socket_sel;
   logic [CELL_W-1:0] cell_sel;
   logic ram_we;
   logic [ADDR_W-1:0] ram_addr;
   logic [W-1:0] ram_wdata;
   logic busy, done;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   lcs_capture_seq #(
      .NUM_SOCKETS(NS), .NUM_CELLS(NC), .NUM_STREAMS(NSTR), .STREAM_BITS(NB),
      .WORD_W(W), .CLK_DIV(DIV), .SETTLE_CYC(SETTLE), .START_CODE(CODE)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
      .chip_clk(chip_clk), .cell_bit(cell_bit), .socket_sel(socket_sel),
      .cell_sel(cell_sel), .ram_we(ram_we), .ram_addr(ram_addr),
      .ram_wdata(ram_wdata), .busy(busy), .done(done)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // latch model: new pseudo-random value after every falling chip clock
   logic [15:0] lfsr = 16'hACE1;
   always @(negedge chip_clk) begin
      lfsr     = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cell_bit = lfsr[0] ^ socket_sel[0] ^ cell_sel[0];
   end

   // monitor: records captured bits and checks every RAM write
   bit exp_bits [TOT_BITS];
   int n_bits = 0, n_words = 0, since = 1000;
   bit cc_prev = 1'b0, done_prev = 1'b0, we_prev = 1'b0;
   always @(negedge clk) begin
      if (chip_clk && !cc_prev) since = 0;
      else if (since < 1000) since++;
      cc_prev = chip_clk;
      if (rst_n && busy && since == SETTLE && n_bits < TOT_BITS) begin
         // R4 capture point, R5 select order
         exp_bits[n_bits] = cell_bit;
         chk(int'(socket_sel) == 1 + n_bits / (NC * NSTR * NB), "R5 socket_sel",
             int'(socket_sel), 1 + n_bits / (NC * NSTR * NB));
         chk(int'(cell_sel) == (n_bits / (NSTR * NB)) % NC, "R5 cell_sel",
             int'(cell_sel), (n_bits / (NSTR * NB)) % NC);
         n_bits++;
      end
      if (rst_n && ram_we) begin
         logic [W-1:0] ew;
         for (int j = 0; j < W; j++) ew[j] = exp_bits[n_words * W + j];
         chk(int'(ram_addr) == n_words, "R7 address", int'(ram_addr), n_words);
         chk(ram_wdata == ew, "R6 packed word", int'(ram_wdata), int'(ew));
         n_words++;
      end
      if (rst_n && done && !done_prev)
         chk(we_prev, "R8 done follows last write", int'(we_prev), 1);
      done_prev = done;
      we_prev   = ram_we;
   end

   task automatic send(input logic [7:0] b);
      @(posedge clk); #1;
      rx_valid = 1'b1; rx_byte = b;
      @(posedge clk); #1;
      rx_valid = 1'b0;
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(!busy && !done, "R10 flags low", int'({busy, done}), 0);
      chk(!ram_we, "R10 no write", int'(ram_we), 0);
      chk(socket_sel == 1 && cell_sel == 0, "R10 selects",
          int'({socket_sel, cell_sel}), 1 << CELL_W);
      chk(chip_clk, "R10 chip_clk high", int'(chip_clk), 1);
      rst_n = 1'b1;
   endtask

   task automatic t_clock();
      int hi = 0, per = 0;
      @(negedge clk);
      while (!(chip_clk && !cc_prev)) @(negedge clk);
      do begin
         if (chip_clk) hi++;
         per++;
         @(negedge clk);
      end while (!(chip_clk && per > 1 && hi == per - (per - hi) && !cc_prev) || per < 2);
      chk(per == DIV, "R3 chip_clk period", per, DIV);
      chk(hi == DIV / 2, "R3 chip_clk high time", hi, DIV / 2);
   endtask

   task automatic t_bad_byte();
      send(8'h3C);
      repeat (3 * DIV) @(negedge clk);
      chk(!busy, "R1 wrong byte ignored", int'(busy), 0);
      chk(n_words == 0, "R1 no writes when idle", n_words, 0);
   endtask

   task automatic t_sweep(input bit poke);
      int guard = 0;
      n_bits = 0; n_words = 0;
      send(CODE);
      @(negedge clk);
      chk(busy && !done, "R1 start accepted", int'({busy, done}), 2);
      if (poke) begin
         while (n_words < 3) @(negedge clk);
         send(CODE);
         @(negedge clk);
         chk(busy, "R2 start ignored while busy", int'(busy), 1);
      end
      while (!done && guard < 5000) begin
         @(negedge clk);
         guard++;
      end
      chk(n_bits == TOT_BITS, "R4 bit count", n_bits, TOT_BITS);
      chk(n_words == TOT_WORDS, "R7 word count", n_words, TOT_WORDS);
      chk(done && !busy, "R8 end flags", int'({busy, done}), 1);
      chk(socket_sel == 1 && cell_sel == 0, "R9 selects rewound",
          int'({socket_sel, cell_sel}), 1 << CELL_W);
      repeat (10) @(negedge clk);
      chk(done, "R8 done held", int'(done), 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      t_reset();
      t_clock();
      t_bad_byte();
      t_sweep(1'b1);
      t_sweep(1'b0);
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end
endmodule